// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block collects nine level-sensitive interrupt sources and presents them on three interrupt request outputs toward a host interrupt controller. Each source is brought into the clock domain through a two-flop synchronizer. A per-source polarity bit then decides whether a high or a low input counts as a request. An active request sets a pending flag for that source. One flag per source is shared by all three outputs.

Software reaches the block over a plain 32-bit strobe bus with a four-bit byte address. The word at offset 0x0 holds the polarity bits. The words at 0x4, 0x8 and 0xC each belong to one output line: 0x4 to line 0, 0x8 to line 1 and 0xC to line 2. In each of these three words, the low field holds that line's source enables and the upper field shows the shared pending flags. A pending flag is cleared by writing a one to its bit. Output line n is high while any source enabled on line n is pending. Software reads the pending field and picks the source it wants to serve.

Top module: `irq_route_ctrl`

## Requirements
- R1: While rst_n is low, the polarity word, all enables and all pending flags are zero, and every irq_o bit is low.
- R2: The word at offset 0x0 holds the polarity in bits [8:0] and reads back in the same bits. A 1 in bit i makes source i active when its input is high. A 0 in bit i makes source i active when its input is low.
- R3: A change on src_i[i] is first seen in pending flag i after the third rising clock edge. Two edges go through the synchronizer and the third edge sets the flag.
- R4: A pending flag stays set after its source goes inactive, until software acknowledges it.
- R5: Writing a 1 to bit 16+i of any line word (0x4, 0x8 or 0xC) clears pending flag i. Writing a 0 to that bit leaves the flag unchanged.
- R6: If source i is still active at the clock edge where it is acknowledged, the set wins and the flag remains set.
- R7: Bits [24:16] of all three line words show the same pending flags, with bit 16+i belonging to source i. This holds whatever the enables are.
- R8: Bits [8:0] of the word at 0x4+4n hold the enables of line n and read back. irq_o[n] is high exactly when some source i has both its pending flag and enable bit i of line n set.
- R9: Bits [31:25] and [15:9] of every word read as zero, as do bits [31:9] of the polarity word. bus_rdata is zero whenever bus_rd is low.
- R10: A write whose address has bits [1:0] other than 00 changes no polarity bit, no enable and no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 9 | Interrupt source inputs, one per source, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 4 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| irq_o | output | 3 | Interrupt request per output line, active high |

## Verification
The bench builds the block with its default parameters: nine sources, three lines and two synchronizer stages. These sizes are small enough to sweep completely. For a set of polarity words and source patterns, the bench reads back the pending field through all three line words. It also enables every single source on every line in turn. The two-stage synchronizer gives a fixed three-edge latency, which the bench samples on either side of the edge where the flag should set. It also checks the set-over-clear case, acknowledges written through a different line than the one being read, and writes to misaligned addresses.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PEND_LSB = 16;
  localparam int unsigned MAX_SRC  = 16;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] pend_q
);
  logic [WIDTH-1:0] active;
  logic [WIDTH-1:0] pend_d;

  // polarity 1: high is a request, polarity 0: low is a request
  assign active = ~(lvl ^ pol);

  // a request at the acknowledge edge overrides the clear
  always_comb pend_d = (pend_q & ~ack) | active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 9,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic                              rd,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [NUM_SRC-1:0]                pend,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NUM_SRC-1:0]                pol_q,
  output logic [NUM_LINES-1:0][NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0]                ack
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             word_ok;
  logic [IDX_W-1:0] word_idx;
  logic             pol_we;
  logic [NUM_LINES-1:0] en_we;
  logic [NUM_SRC-1:0]   pol_d;
  logic [NUM_SRC-1:0]   field_en;
  logic [NUM_SRC-1:0]   field_ack;
  logic                 unused_wdata;

  assign word_ok   = (addr[1:0] == 2'b00);
  assign word_idx  = addr[ADDR_W-1:2];
  assign field_en  = wdata[NUM_SRC-1:0];
  assign field_ack = wdata[PEND_LSB +: NUM_SRC];
  assign unused_wdata = ^{wdata[DATA_W-1:PEND_LSB+NUM_SRC], wdata[PEND_LSB-1:NUM_SRC]};

  always_comb begin
    pol_we = wr && word_ok && (word_idx == '0);
    pol_d  = field_en;
    ack    = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      en_we[l] = wr && word_ok && (word_idx == IDX_W'(l + 1));
      if (en_we[l]) ack = field_ack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_we) pol_q <= pol_d;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q[l] <= '0;
      else if (en_we[l]) en_q[l] <= field_en;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && word_ok) begin
      if (word_idx == '0) rdata[NUM_SRC-1:0] = pol_q;
      for (int l = 0; l < NUM_LINES; l++) begin
        if (word_idx == IDX_W'(l + 1)) begin
          rdata[NUM_SRC-1:0]          = en_q[l];
          rdata[PEND_LSB +: NUM_SRC]  = pend;
        end
      end
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 9,
  parameter int unsigned NUM_LINES   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = $clog2(4 * (NUM_LINES + 1))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_SRC-1:0]                lvl;
  logic [NUM_SRC-1:0]                pol;
  logic [NUM_SRC-1:0]                ack;
  logic [NUM_SRC-1:0]                pend;
  logic [NUM_LINES-1:0][NUM_SRC-1:0] en;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_i), .dout(lvl)
  );

  irq_pend #(.WIDTH(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .pol(pol), .ack(ack), .pend_q(pend)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .pend(pend), .rdata(bus_rdata), .pol_q(pol),
    .en_q(en), .ack(ack)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign irq_o[l] = |(pend & en[l]);
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 9,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] irq_o
);
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_QUIET: assert (irq_o == '0); // R1
    end
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R9

  AST_GAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[DATA_W-1:PEND_LSB+NUM_SRC] == '0) &&
               (bus_rdata[PEND_LSB-1:NUM_SRC] == '0)); // R9

  AST_POL_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |-> bus_rdata[DATA_W-1:NUM_SRC] == '0); // R2

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(4 * (l + 1))) |->
      ((|(bus_rdata[PEND_LSB +: NUM_SRC] & bus_rdata[NUM_SRC-1:0])) == irq_o[l])); // R8
  end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_o(irq_o)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  localparam int NS = 9;
  localparam int NL = 3;
  localparam logic [8:0] ALL = 9'h1FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] m_en [NL];
  logic [8:0] m_pol;

  always #2.5 clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #0.5;
    v = bus_rdata;
    bus_rd = 1'b0;
    #0.5;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] line_word(input logic [8:0] p, input logic [8:0] e);
    return {7'b0, p, 7'b0, e};
  endfunction

  function automatic logic [8:0] act_of(input logic [8:0] s, input logic [8:0] p);
    return ~(s ^ p);
  endfunction

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [8:0] pols [4];
    logic [8:0] pats [6];
    pols = '{9'h000, 9'h1FF, 9'h0AA, 9'h133};
    pats = '{9'h000, 9'h1FF, 9'h155, 9'h0F0, 9'h101, 9'h03C};
    for (int l = 0; l < NL; l++) m_en[l] = '0;
    m_pol = '0;

    // R1: reset state
    src_i = 9'h000;
    wait_cyc(3);
    rd_reg(4'h0, v);  chk("R1 pol", v, 32'h0);
    for (int l = 0; l < NL; l++) begin
      rd_reg(4'(4 * (l + 1)), v); chk("R1 line", v, 32'h0);
    end
    chk("R1 irq", {29'b0, irq_o}, 32'h0);

    // release with all sources inactive-low
    src_i = ALL;
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(4);
    wr_reg(4'h4, 32'h01FF_0000);
    rd_reg(4'h4, v); chk("R5 initial ack", v, 32'h0);

    // R3: latency of three edges, source 4 active low
    src_i[4] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd_reg(4'h4, v); chk("R3 not before third edge", v, line_word(9'h000, 9'h000));
    @(posedge clk); @(negedge clk);
    rd_reg(4'h4, v); chk("R3 set on third edge", v, line_word(9'h010, 9'h000));

    // R6: ack while active keeps it set
    wr_reg(4'h8, 32'h0010_0000);
    rd_reg(4'h4, v); chk("R6 set wins", v, line_word(9'h010, 9'h000));

    // R4: sticky after source leaves
    src_i[4] = 1'b1;
    wait_cyc(6);
    rd_reg(4'hC, v); chk("R4 sticky", v, line_word(9'h010, 9'h000));

    // R5: writing zeros does not clear; one through line 2 clears
    wr_reg(4'h8, 32'h0000_0000);
    rd_reg(4'h4, v); chk("R5 zero keeps", v, line_word(9'h010, 9'h000));
    wr_reg(4'hC, 32'h0010_0000);
    rd_reg(4'h4, v); chk("R5 one clears", v, line_word(9'h000, 9'h000));

    // R2, R7, R8 sweep
    foreach (pols[pi]) begin
      m_pol = pols[pi];
      wr_reg(4'h0, {23'b0, m_pol});
      rd_reg(4'h0, v); chk("R2 pol readback", v, {23'b0, m_pol});
      foreach (pats[si]) begin
        logic [8:0] exp_p;
        src_i = pats[si];
        exp_p = act_of(pats[si], m_pol);
        wait_cyc(4);
        m_en[0] = '0;
        wr_reg(4'h4, 32'h01FF_0000);
        for (int l = 0; l < NL; l++) begin
          rd_reg(4'(4 * (l + 1)), v);
          chk("R2 R7 pending per polarity", v, line_word(exp_p, m_en[l]));
        end
        for (int l = 0; l < NL; l++) begin
          for (int i = 0; i < NS; i++) begin
            m_en[l] = 9'(1 << i);
            wr_reg(4'(4 * (l + 1)), {23'b0, m_en[l]});
            chk("R8 single enable", {31'b0, irq_o[l]}, {31'b0, exp_p[i]});
          end
          m_en[l] = 9'(pi * 37 + si * 11 + l * 5) & ALL;
          wr_reg(4'(4 * (l + 1)), {23'b0, m_en[l]});
          rd_reg(4'(4 * (l + 1)), v);
          chk("R8 enable readback", v, line_word(exp_p, m_en[l]));
          chk("R8 irq pattern", {31'b0, irq_o[l]}, {31'b0, |(exp_p & m_en[l])});
        end
      end
    end

    // R9: idle read data is zero; unused bits zero even if written
    bus_addr = 4'h4;
    #0.5; chk("R9 idle rdata", bus_rdata, 32'h0); #0.5;
    m_en[1] = 9'h1A5;
    wr_reg(4'h8, 32'hFE00_FFA5 & 32'hFE00_FFFF);
    rd_reg(4'h8, v);
    chk("R9 unused bits", v & 32'hFE00_FE00, 32'h0);
    chk("R9 enable field", {23'b0, v[8:0]}, {23'b0, m_en[1]});
    wr_reg(4'h0, 32'hFFFF_FFFF); m_pol = ALL;
    rd_reg(4'h0, v); chk("R9 pol width", v, 32'h0000_01FF);

    // R10: misaligned writes ignored; pending set with src high, pol all-high
    src_i = 9'h0F3;
    wait_cyc(4);
    rd_reg(4'h4, v);
    begin
      logic [8:0] p_before;
      p_before = v[24:16];
      for (int a = 1; a < 16; a++) begin
        if ((a & 3) != 0) wr_reg(4'(a), 32'hFFFF_FFFF);
      end
      src_i = 9'h000;
      wait_cyc(4);
      rd_reg(4'h0, v); chk("R10 pol kept", v, {23'b0, m_pol});
      for (int l = 0; l < NL; l++) begin
        rd_reg(4'(4 * (l + 1)), v);
        chk("R10 line kept", v, line_word(p_before, m_en[l]));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule